// File: doc/BRIEF.md
# Processor Power-Down and Wake-Up Controller

This controller sits beside a small processor core and decides when the core's clock may be stopped and how the core comes back. Software writes a six-bit power-down field, held in bits 15..10 of a control/status register, in one store. A mode written into the field is acted on only after a fixed entry delay. Once the delay has run out, the controller raises a clock-gate request and a halt indication.

There are three sleep depths. The light depth ends on an interrupt. Software picks whether that interrupt must be enabled in the per-line mask or may be any raw request. The two deep depths ignore every interrupt and end only on reset.

On every exit from the light depth, the controller does three things. It clears the field. It pulses a wake strobe. It tells the sequencer whether to service the interrupt first or to resume at the next instruction.

Top module: `pwr_down_ctl`

## Requirements
- R1: When `csr_we` is high in run mode, `csr_wdata[14:10]` is loaded into `pwr_field[4:0]` at that clock edge. `pwr_field` reads back the stored field.
- R2: `pwr_field[5]` (register bit 15) always reads 0, whatever value is written to `csr_wdata[15]`.
- R3: `pwr_field[2:0]` selects the mode: 001 selects the light depth, 010 and 100 select the deep depths, and 000 is run. Any other value is treated as run: the field still reads back as written, and the outputs stay low.
- R4: After a write that selects a sleep depth, `clk_gate_req` and `core_halt` go high together exactly ENTRY_DLY (9) clock edges after the edge that sampled the write. Before that they stay low.
- R5: In the light depth, `pwr_field[3]` (bit 13) enables wake on any line with both `irq_req` and `irq_en` high. `pwr_field[4]` (bit 14) enables wake on any `irq_req` line. With neither bit set, no interrupt wakes the block.
- R6: On a light-depth wake, `clk_gate_req` and `core_halt` drop, and the field reads back 0, at the same edge. `wake_valid` pulses high for exactly one cycle.
- R7: In the deep depths, interrupts have no effect. The outputs stay high until reset.
- R8: At a wake, `wake_service` is 1 only if an enabled interrupt line was pending and both `gie` and `nmie` were 1. Otherwise it is 0, which means resume at the next instruction.
- R9: During the entry delay of the light depth, a qualifying wake interrupt cancels entry. The cancel behaves as a wake under R6 and R8, and the gate request never rises. During a deep-depth entry delay, interrupts do not stop entry.
- R10: Writes made during the entry delay or during sleep are ignored.
- R11: A synchronous active-high `rst` clears the field and the delay, returns the block to run mode, and drives every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Control/status register write strobe |
| csr_wdata | input | 16 | Control/status register write data; bits 15..10 carry the field |
| irq_req | input | NIRQ | Raw interrupt request lines |
| irq_en | input | NIRQ | Per-line interrupt enable mask |
| gie | input | 1 | Global interrupt enable |
| nmie | input | 1 | Non-maskable interrupt enable |
| pwr_field | output | 6 | Readback of register bits 15..10 |
| clk_gate_req | output | 1 | Request to stop the core clock |
| core_halt | output | 1 | Core is halted in a sleep depth |
| wake_valid | output | 1 | One-cycle strobe on a wake or a cancelled entry |
| wake_service | output | 1 | With wake_valid: 1 = service the interrupt first, 0 = plain resume |

## Verification
The hardest state to reach from the ports is a qualifying interrupt that lands inside the nine-cycle entry window. Nearly as hard is an interrupt landing on the window's last edge, where a cancel and the entry compete. Directed tests place interrupts at chosen cycles of that window for both light and deep depths, and also issue a second write inside it. A long seeded random run then mixes sparse single-line interrupts, random masks and enables, occasional resets and biased mode writes. This mix reaches cancels at varied offsets and wakes under every setting of the enables. A cycle model in the bench follows the random run.

// File: rtl/pwr_down_ctl.sv
module pwr_down_ctl #(
  parameter int NIRQ      = 16,
  parameter int ENTRY_DLY = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            csr_we,
  input  logic [15:0]     csr_wdata,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            gie,
  input  logic            nmie,
  output logic [5:0]      pwr_field,
  output logic            clk_gate_req,
  output logic            core_halt,
  output logic            wake_valid,
  output logic            wake_service
);

  localparam int CW = $clog2(ENTRY_DLY + 1);

  typedef enum logic [1:0] {S_RUN, S_ARM, S_DOWN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [4:0]    fld;

  wire [2:0] wmode   = csr_wdata[12:10];
  wire       wr_pd   = (wmode == 3'b001) || (wmode == 3'b010) || (wmode == 3'b100);
  wire       sel_lt  = (fld[2:0] == 3'b001);
  wire       en_hit  = |(irq_req & irq_en);
  wire       raw_hit = |irq_req;
  wire       wake    = sel_lt && ((fld[3] && en_hit) || (fld[4] && raw_hit));
  wire       svc     = en_hit && gie && nmie;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_RUN;
      cnt          <= '0;
      fld          <= '0;
      wake_valid   <= 1'b0;
      wake_service <= 1'b0;
    end else begin
      wake_valid   <= 1'b0;
      wake_service <= 1'b0;
      case (st)
        S_RUN: begin
          if (csr_we) begin
            fld <= csr_wdata[14:10];
            if (wr_pd) begin
              st  <= S_ARM;
              cnt <= CW'(ENTRY_DLY);
            end
          end
        end
        default: begin
          if (wake) begin
            st           <= S_RUN;
            fld          <= '0;
            cnt          <= '0;
            wake_valid   <= 1'b1;
            wake_service <= svc;
          end else if (st == S_ARM) begin
            if (cnt == CW'(1)) st <= S_DOWN;
            cnt <= cnt - CW'(1);
          end
        end
      endcase
    end
  end

  assign pwr_field    = {1'b0, fld};
  assign clk_gate_req = (st == S_DOWN);
  assign core_halt    = (st == S_DOWN);

endmodule

// File: rtl/pwr_down_ctl_chk.sv
module pwr_down_ctl_chk #(
  parameter int NIRQ = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [NIRQ-1:0] irq_req,
  input logic [NIRQ-1:0] irq_en,
  input logic            gie,
  input logic            nmie,
  input logic [5:0]      pwr_field,
  input logic            clk_gate_req,
  input logic            core_halt,
  input logic            wake_valid,
  input logic            wake_service
);

  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    pwr_field[5] == 1'b0);

  a_r4_gate_halt_pair: assert property (@(posedge clk) disable iff (rst)
    clk_gate_req == core_halt);

  a_r7_deep_holds: assert property (@(posedge clk) disable iff (rst)
    (clk_gate_req && pwr_field[2:0] != 3'b001) |=> clk_gate_req);

  a_r6_exit_clears: assert property (@(posedge clk) disable iff (rst)
    ($fell(clk_gate_req) && !$past(rst)) |-> (pwr_field == 6'd0 && wake_valid));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wake_valid |=> !wake_valid);

  a_r8_service_qualified: assert property (@(posedge clk) disable iff (rst)
    (wake_valid && wake_service) |-> $past(gie && nmie && |(irq_req & irq_en)));

  a_r10_field_frozen: assert property (@(posedge clk) disable iff (rst)
    clk_gate_req |=> (clk_gate_req ? $stable(pwr_field) : pwr_field == 6'd0));

  a_r11_reset_state: assert property (@(posedge clk)
    rst |=> (!clk_gate_req && !core_halt && !wake_valid && pwr_field == 6'd0));

endmodule

bind pwr_down_ctl pwr_down_ctl_chk #(.NIRQ(NIRQ)) chk_i (
  .clk(clk), .rst(rst), .irq_req(irq_req), .irq_en(irq_en), .gie(gie), .nmie(nmie),
  .pwr_field(pwr_field), .clk_gate_req(clk_gate_req), .core_halt(core_halt),
  .wake_valid(wake_valid), .wake_service(wake_service)
);

// File: tb/pwr_down_ctl_tb_top.sv
`timescale 1ns/1ps
module pwr_down_ctl_tb_top;
  localparam int NIRQ = 16;
  localparam int DLY  = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we = 1'b0;
  logic [15:0] wd = '0;
  logic [NIRQ-1:0] irq = '0, ien = '0;
  logic gie = 1'b1, nmie = 1'b1;
  logic [5:0] fld;
  logic gate, halt, wv, ws;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwr_down_ctl #(.NIRQ(NIRQ), .ENTRY_DLY(DLY)) dut_i (
    .clk(clk), .rst(rst), .csr_we(we), .csr_wdata(wd), .irq_req(irq), .irq_en(ien),
    .gie(gie), .nmie(nmie), .pwr_field(fld), .clk_gate_req(gate), .core_halt(halt),
    .wake_valid(wv), .wake_service(ws));

  function automatic bit sleep_mode(input logic [2:0] m);
    return (m == 3'b001) || (m == 3'b010) || (m == 3'b100);
  endfunction

  function automatic bit qualifies(input logic [4:0] f, input logic [NIRQ-1:0] r, input logic [NIRQ-1:0] e);
    return (f[2:0] == 3'b001) && ((f[3] && |(r & e)) || (f[4] && |r));
  endfunction

  int m_st = 0, m_up = 0;
  logic [4:0] m_f = '0;
  logic m_wv = 1'b0, m_ws = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_st <= 0; m_up <= 0; m_f <= '0; m_wv <= 1'b0; m_ws <= 1'b0;
    end else begin
      m_wv <= 1'b0; m_ws <= 1'b0;
      if (m_st == 0) begin
        if (we) begin
          m_f <= wd[14:10];
          if (sleep_mode(wd[12:10])) begin m_st <= 1; m_up <= 0; end
        end
      end else if (qualifies(m_f, irq, ien)) begin
        m_st <= 0; m_f <= '0; m_wv <= 1'b1; m_ws <= (|(irq & ien)) && gie && nmie;
      end else if (m_st == 1) begin
        if (m_up == DLY - 1) m_st <= 2;
        m_up <= m_up + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (!done) begin
      chk("R1 model field", 32'(fld), 32'({1'b0, m_f}));
      chk("R4 model gate", 32'(gate), 32'(m_st == 2));
      chk("R4 model halt", 32'(halt), 32'(m_st == 2));
      chk("R6 model wake_valid", 32'(wv), 32'(m_wv));
      chk("R8 model wake_service", 32'(ws), 32'(m_ws));
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  task automatic wr(input logic [5:0] f);
    we = 1'b1; wd = {f, 10'h2A5}; step(1); we = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; step(1); rst = 1'b0; step(1);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    step(2);
    chk("R11 reset field", 32'(fld), 0);
    chk("R11 reset gate", 32'(gate), 0);
    chk("R11 reset wake", 32'(wv), 0);
    rst = 1'b0; step(1);

    // R1 R2 R4: light depth, any-wake, bit 15 written as 1
    wr(6'b110001);
    chk("R2 reserved bit reads 0", 32'(fld), 32'h11);
    step(DLY - 1);
    chk("R4 gate low one edge early", 32'(gate), 0);
    step(1);
    chk("R4 gate high at delay", 32'(gate), 1);
    chk("R4 halt high at delay", 32'(halt), 1);
    irq = 16'h0001; ien = '0; gie = 1; nmie = 1;
    step(1);
    chk("R6 gate drops on wake", 32'(gate), 0);
    chk("R6 field cleared", 32'(fld), 0);
    chk("R6 wake pulse", 32'(wv), 1);
    chk("R8 non-enabled irq resumes", 32'(ws), 0);
    irq = '0; step(1);
    chk("R6 pulse one cycle", 32'(wv), 0);

    // R5 R8: enabled-only wake
    wr(6'b001001); step(DLY);
    irq = 16'h0004; ien = 16'h0001; step(3);
    chk("R5 unmasked-off irq ignored", 32'(gate), 1);
    ien = 16'h0004; gie = 0; step(1);
    chk("R5 enabled irq wakes", 32'(gate), 0);
    chk("R8 gie low gives resume", 32'(ws), 0);
    irq = '0; gie = 1; step(1);

    wr(6'b001001); step(DLY);
    irq = 16'h8000; ien = 16'h8000; step(1);
    chk("R8 service requested", 32'(ws), 1);
    chk("R8 wake pulse", 32'(wv), 1);
    irq = '0; nmie = 0; step(1);
    wr(6'b001001); step(DLY);
    irq = 16'h8000; step(1);
    chk("R8 nmie low gives resume", 32'(ws), 0);
    irq = '0; nmie = 1; ien = '0; step(1);

    // R7 R9 R10 R11: PD2 with interrupts everywhere
    irq = '1; ien = '1;
    wr(6'b010010);
    step(DLY);
    chk("R9 deep entry not cancelled", 32'(gate), 1);
    step(20);
    chk("R7 deep ignores irq", 32'(gate), 1);
    we = 1'b1; wd = 16'h0000; step(1); we = 1'b0; step(1);
    chk("R10 write in sleep ignored", 32'(fld), 32'h12);
    rst = 1'b1; step(1);
    chk("R11 reset ends deep gate", 32'(gate), 0);
    chk("R11 reset clears field", 32'(fld), 0);
    rst = 1'b0; irq = '0; step(1);

    // R7 R9: PD3 with irq during delay
    wr(6'b001100); step(3); irq = 16'h0010; ien = 16'h0010; step(DLY - 3);
    chk("R9 PD3 entry completes", 32'(gate), 1);
    step(10);
    chk("R7 PD3 holds", 32'(gate), 1);
    irq = '0; ien = '0; do_reset();

    // R9: cancel light entry mid-delay
    wr(6'b010001); step(3); irq = 16'h0100; step(1);
    chk("R9 cancel wake pulse", 32'(wv), 1);
    chk("R9 cancel clears field", 32'(fld), 0);
    irq = '0; step(10);
    chk("R9 gate never rises", 32'(gate), 0);

    // R3: illegal and zero modes
    wr(6'b000011);
    chk("R3 illegal readback", 32'(fld), 32'h03);
    step(12);
    chk("R3 illegal stays run", 32'(gate), 0);
    wr(6'b011000); step(12);
    chk("R3 zero mode stays run", 32'(gate), 0);
    chk("R3 zero mode readback", 32'(fld), 32'h18);

    // R10: write inside delay ignored
    wr(6'b010001); step(2);
    we = 1'b1; wd = {6'b000100, 10'h0}; step(1); we = 1'b0;
    chk("R10 write in delay ignored", 32'(fld), 32'h11);
    step(DLY - 3);
    chk("R10 original entry kept", 32'(gate), 1);
    irq = 16'h0002; step(1); irq = '0; step(1);

    // R5: light depth with no wake bits
    wr(6'b000001); step(DLY);
    irq = '1; ien = '1; step(5);
    chk("R5 no wake bits holds", 32'(gate), 1);
    irq = '0; ien = '0; do_reset();

    // random phase, checked by the model
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] pick;
      rst = ($urandom % 200) == 0;
      we  = ($urandom % 8) == 0;
      case ($urandom % 8)
        0, 1, 2: pick = 3'b001;
        3: pick = 3'b010;
        4: pick = 3'b100;
        5: pick = 3'b000;
        6: pick = 3'b011;
        default: pick = 3'b110;
      endcase
      wd = 16'($urandom);
      wd[12:10] = pick;
      irq  = (($urandom % 6) == 0) ? NIRQ'(1) << ($urandom % NIRQ) : '0;
      ien  = NIRQ'($urandom);
      gie  = ($urandom % 4) != 0;
      nmie = ($urandom % 4) != 0;
      step(1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule